// File: doc/BRIEF.md
# Word-Granular Data Memory with Packed Edit Bus

This block is the data store of a small processor. It keeps an array of 32-bit words and serves one read port and one write port. A read needs a 32-bit fetch address and gives back a registered 32-bit word. Writes do not use separate enable, address and data pins. They arrive on one 65-bit edit bus, which packs a request flag, a target address and the data word together. A clock-enable input gates both reads and writes.

The array counts its locations in words. A processor core works in byte addresses, so those must be divided by four before they index the array. The parameter `CPU_BYTE_ADDR` sets where that happens. When it is 0, the fetch and edit addresses are taken as word indices. When it is 1, an internal conversion stage shifts them right by two. A third port, the dump port, reads any word by word index on every clock. A testbench uses it to walk the whole array and print it.

Top module: `word_data_mem`

## Requirements
- R1: The edit bus layout is: bit 64 is the write request, bits 63:32 are the target address and bits 31:0 are the data. With `en` high and bit 64 at 1, the data is stored at the target on the rising clock edge.
- R2: A write does not happen when bit 64 is 0 or when `en` is low. The addressed word keeps its old contents.
- R3: With `en` high on an edge, `rd_word` shows the word at `fetch_addr` after that edge.
- R4: While `en` is low, `rd_word` holds its last value, even if `fetch_addr` changes.
- R5: Synchronous reset sets `rd_word` and `dump_word` to zero. The stored words are left unchanged.
- R6: A read and a write may target the same word on the same edge. The read then returns the contents from before the write.
- R7: The array uses only the low log2(DEPTH) bits of the word index. Addresses beyond the depth wrap modulo DEPTH, which must be a power of two.
- R8: With `CPU_BYTE_ADDR`=1, the fetch and edit addresses are byte addresses. The word index is the address shifted right by 2, and the two low bits are ignored.
- R9: `dump_word` shows the word at word index `dump_addr` one edge later. This port ignores `en` and does not disturb `rd_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| en | input | 1 | Clock enable for reads and writes |
| fetch_addr | input | 32 | Read address (word, or byte when CPU_BYTE_ADDR=1) |
| edit_bus | input | 65 | {write request, target address, data} |
| rd_word | output | 32 | Registered read data |
| dump_addr | input | 32 | Word index for the dump port |
| dump_word | output | 32 | Registered dump data |

## Verification
The bench builds two copies of the block.

- **Word-addressed copy.** This copy has DEPTH=16 and CPU_BYTE_ADDR=0. With only sixteen words, every location can be written and read back through both ports. Addresses such as 18 and 0xFFFFFFF9 then wrap to known words.
- **Byte-addressed copy.** This copy has DEPTH=8 and CPU_BYTE_ADDR=1. It checks the shift stage, covering byte addresses whose low two bits are not zero and byte addresses that wrap past the small array.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 32;
  localparam int EDIT_W = 1 + ADDR_W + WORD_W;

  // bit 64 request, 63:32 address, 31:0 data
  typedef struct packed {
    logic              req;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } edit_t;
endpackage

// File: rtl/dmem_addr_map.sv
module dmem_addr_map #(
  parameter int DEPTH         = 64,
  parameter bit CPU_BYTE_ADDR = 1'b0,
  localparam int AW           = $clog2(DEPTH)
) (
  input  logic [dmem_pkg::ADDR_W-1:0] in_addr,
  output logic [AW-1:0]               idx
);
  logic [dmem_pkg::ADDR_W-1:0] word_addr;

  generate
    if (CPU_BYTE_ADDR) begin : g_byte
      assign word_addr = in_addr >> 2;
    end else begin : g_word
      assign word_addr = in_addr;
    end
  endgenerate

  // R7: upper bits dropped, accesses wrap modulo DEPTH
  assign idx = AW'(word_addr);
endmodule

// File: rtl/dmem_edit_unpack.sv
module dmem_edit_unpack (
  input  logic                        en,
  input  logic [dmem_pkg::EDIT_W-1:0] edit_bus,
  output logic                        we,
  output logic [dmem_pkg::ADDR_W-1:0] waddr,
  output logic [dmem_pkg::WORD_W-1:0] wdata
);
  dmem_pkg::edit_t ed;

  assign ed    = dmem_pkg::edit_t'(edit_bus);
  assign we    = en & ed.req;
  assign waddr = ed.addr;
  assign wdata = ed.data;
endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = dmem_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  input  logic [AW-1:0] dump_idx,
  output logic [DW-1:0] rd_q,
  output logic [DW-1:0] dump_q
);
  logic [DW-1:0] mem [DEPTH];

  // write port, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
  end

  // read-first output register
  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (en) rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) dump_q <= '0;
    else     dump_q <= mem[dump_idx];
  end

  // R1
  write_land_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wr_idx)] == $past(wr_data));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rd_q));

  // R5
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_q == '0 && dump_q == '0));

  // R6
  read_old_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> rd_q == $past(mem[rd_idx]));
endmodule

// File: rtl/word_data_mem.sv
module word_data_mem #(
  parameter int DEPTH         = 64,
  parameter bit CPU_BYTE_ADDR = 1'b0,
  localparam int AW           = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] fetch_addr,
  input  logic [64:0] edit_bus,
  output logic [31:0] rd_word,
  input  logic [31:0] dump_addr,
  output logic [31:0] dump_word
);
  logic          we;
  logic [31:0]   waddr;
  logic [31:0]   wdata;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;
  logic [AW-1:0] dump_idx;

  dmem_edit_unpack u_unpack (
    .en      (en),
    .edit_bus(edit_bus),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata)
  );

  dmem_addr_map #(.DEPTH(DEPTH), .CPU_BYTE_ADDR(CPU_BYTE_ADDR)) u_wmap (
    .in_addr(waddr),
    .idx    (wr_idx)
  );

  dmem_addr_map #(.DEPTH(DEPTH), .CPU_BYTE_ADDR(CPU_BYTE_ADDR)) u_rmap (
    .in_addr(fetch_addr),
    .idx    (rd_idx)
  );

  // dump port always indexes words
  dmem_addr_map #(.DEPTH(DEPTH), .CPU_BYTE_ADDR(1'b0)) u_dmap (
    .in_addr(dump_addr),
    .idx    (dump_idx)
  );

  dmem_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .we      (we),
    .wr_idx  (wr_idx),
    .wr_data (wdata),
    .rd_idx  (rd_idx),
    .dump_idx(dump_idx),
    .rd_q    (rd_word),
    .dump_q  (dump_word)
  );
endmodule

// File: tb/word_data_mem_tb.sv
`timescale 1ns/1ps
module word_data_mem_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // word-addressed copy, DEPTH 16
  logic        en = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic [64:0] edit_bus = '0;
  logic [31:0] dump_addr = '0;
  logic [31:0] rd_word, dump_word;

  // byte-addressed copy, DEPTH 8
  logic        en_b = 1'b0;
  logic [31:0] fetch_b = '0;
  logic [64:0] edit_b = '0;
  logic [31:0] dump_addr_b = '0;
  logic [31:0] rd_b, dumpw_b;

  word_data_mem #(.DEPTH(16), .CPU_BYTE_ADDR(1'b0)) u_dut (
    .clk(clk), .rst(rst), .en(en), .fetch_addr(fetch_addr),
    .edit_bus(edit_bus), .rd_word(rd_word),
    .dump_addr(dump_addr), .dump_word(dump_word));

  word_data_mem #(.DEPTH(8), .CPU_BYTE_ADDR(1'b1)) u_dut_b (
    .clk(clk), .rst(rst), .en(en_b), .fetch_addr(fetch_b),
    .edit_bus(edit_b), .rd_word(rd_b),
    .dump_addr(dump_addr_b), .dump_word(dumpw_b));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] model [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [64:0] mk_edit(input bit req, input logic [31:0] a, input logic [31:0] d);
    return {req, a, d};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    tick();
    tick();
    chk("R5 rd_word after reset", rd_word, 32'h0);
    chk("R5 dump_word after reset", dump_word, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_write_read();
    en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      model[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
      edit_bus = mk_edit(1'b1, i, model[i]);
      tick();
    end
    edit_bus = '0;
    for (int i = 0; i < 16; i++) begin
      fetch_addr = i;
      dump_addr  = 15 - i;
      tick();
      chk("R1/R3 read back", rd_word, model[i]);
      chk("R9 dump read", dump_word, model[15-i]);
    end
  endtask

  task automatic t_no_write();
    en = 1'b1;
    edit_bus = mk_edit(1'b0, 3, 32'hDEAD_0003);
    tick();
    en = 1'b0;
    edit_bus = mk_edit(1'b1, 4, 32'hDEAD_0004);
    tick();
    edit_bus = '0;
    dump_addr = 3;
    tick();
    chk("R2 flag low no write", dump_word, model[3]);
    dump_addr = 4;
    tick();
    chk("R2 en low no write", dump_word, model[4]);
  endtask

  task automatic t_hold();
    en = 1'b1;
    fetch_addr = 5;
    tick();
    chk("R3 read addr 5", rd_word, model[5]);
    en = 1'b0;
    fetch_addr = 6;
    tick();
    tick();
    chk("R4 hold while en low", rd_word, model[5]);
    dump_addr = 9;
    tick();
    chk("R9 dump ignores en", dump_word, model[9]);
    chk("R9 dump leaves rd_word", rd_word, model[5]);
  endtask

  task automatic t_same();
    en = 1'b1;
    fetch_addr = 7;
    edit_bus = mk_edit(1'b1, 7, 32'h1234_5678);
    tick();
    chk("R6 same-word read gives old", rd_word, model[7]);
    model[7] = 32'h1234_5678;
    edit_bus = '0;
    tick();
    chk("R6 next read gives new", rd_word, model[7]);
  endtask

  task automatic t_wrap();
    en = 1'b1;
    edit_bus = mk_edit(1'b1, 18, 32'hCAFE_0012);
    tick();
    model[2] = 32'hCAFE_0012;
    edit_bus = '0;
    dump_addr = 2;
    fetch_addr = 32'hFFFF_FFF9;
    tick();
    chk("R7 write 18 lands on 2", dump_word, model[2]);
    chk("R7 read FFFFFFF9 wraps to 9", rd_word, model[9]);
  endtask

  task automatic t_reset_keep();
    en = 1'b1;
    fetch_addr = 1;
    rst = 1'b1;
    tick();
    chk("R5 reset clears rd_word", rd_word, 32'h0);
    chk("R5 reset clears dump_word", dump_word, 32'h0);
    rst = 1'b0;
    tick();
    chk("R5 contents kept", rd_word, model[1]);
  endtask

  task automatic t_byte();
    en_b = 1'b1;
    edit_b = mk_edit(1'b1, 32'd12, 32'hB000_0003);
    tick();
    edit_b = mk_edit(1'b1, 32'h1D, 32'hB000_0007);
    tick();
    edit_b = mk_edit(1'b1, 32'd36, 32'hB000_0001);
    tick();
    edit_b = '0;
    fetch_b = 32'h0E;
    dump_addr_b = 7;
    tick();
    chk("R8 byte 0x0E reads word 3", rd_b, 32'hB000_0003);
    chk("R8 byte 0x1D wrote word 7", dumpw_b, 32'hB000_0007);
    fetch_b = 32'd4;
    dump_addr_b = 9;
    tick();
    chk("R8 byte 36 wraps to word 1", rd_b, 32'hB000_0001);
    chk("R7 dump index 9 wraps to 1", dumpw_b, 32'hB000_0001);
  endtask

  initial begin
    #1;
    t_reset();
    t_write_read();
    t_no_write();
    t_hold();
    t_same();
    t_wrap();
    t_reset_keep();
    t_byte();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule